// File: doc/BRIEF.md
# Line-Windowed Video Pulse Detector

This block follows a digital video timing stream in the pixel clock domain and counts narrow pseudo-sync pulses. A pulse is counted only when it arrives inside a window of lines near the top of each field. A field-start marker resets a line counter, and each horizontal sync moves the counter on by one line. A pulse-present strobe, qualified by that line number, feeds two counters. One counter takes every pulse inside the window. The other takes only the pulses in the final three lines of the window.

When the horizontal sync that closes the last window line arrives, the block gives its verdict for the field and latches the window pulse count. In standard-definition interlaced mode the verdict depends on whether the final three lines carried enough pulses. A 2-bit code selects that minimum. In progressive mode the tail minimum is not applied, and any pulse inside the window is enough. An override input chooses the window: either built-in line numbers or the start and end lines supplied on the ports.

Top module: `vid_pulse_window_det`

## Requirements
- R1: `field_start` sets the current line number to 0. Each `hsync` without `field_start` adds one to the line number, which holds at 63 once it gets there.
- R2: With `win_override`=0 the window is lines 12 to 21 inclusive, and the 21 matches the end line that a reset configuration would hold. With `win_override`=1 the window is `reg_start_line` to `reg_end_line` inclusive. A start line above the end line gives an empty window.
- R3: A pulse strobe on a line outside the window changes neither count.
- R4: The tail is the last three lines of the window, from end-2 to end. When the window is shorter than three lines, the tail starts at the start line. Only tail pulses count toward the threshold.
- R5: In standard-definition mode (`prog_mode`=0), `detected` is set only if the tail count is at least the threshold that `limit_sel` selects: code 2'b00 gives 6, 2'b01 gives 4, 2'b10 gives 5 and 2'b11 gives 7. Code 2'b10 is the reset configuration. A shorter tail clears `detected` for that field.
- R6: In progressive mode (`prog_mode`=1), the tail threshold is not applied. `detected` is 1 exactly when at least one pulse fell inside the window.
- R7: `detected` and `field_pulse_cnt` change only on the cycle after the `hsync` that leaves the window's end line. This happens at most once per field, and both outputs hold their values for the rest of the time.
- R8: `field_pulse_cnt` reports how many pulses fell inside the window during the evaluated field, including a pulse on the closing cycle. It saturates at 255.
- R9: After reset `detected` is 0 and `field_pulse_cnt` is 0.
- R10: `field_start` clears both pulse counts, so pulses from an abandoned field are not carried into the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start | input | 1 | One-cycle marker at the start of a field |
| hsync | input | 1 | One-cycle marker at the end of each line |
| pulse_strobe | input | 1 | One-cycle strobe for each pseudo-sync pulse seen |
| prog_mode | input | 1 | 0 = standard-definition interlaced, 1 = progressive scan |
| win_override | input | 1 | 0 = built-in window, 1 = window from the line ports |
| reg_start_line | input | 6 | First window line when overridden |
| reg_end_line | input | 6 | Last window line when overridden |
| limit_sel | input | 2 | Tail pulse threshold code |
| detected | output | 1 | Pulse pattern found in the last evaluated field |
| field_pulse_cnt | output | 8 | Window pulse count of the last evaluated field |

## Verification
The bench checks the built-in window in two ways. Pulses spread evenly over the window miss the default tail threshold. Doubling the pulses on every line then meets it, which shows that only the tail decides the verdict. For each threshold code the bench sends exactly the threshold and one less, and places extra pulses early in the window so that tail counting is told apart from window counting. Pulses placed just outside the window, in a register-supplied window away from the built-in lines, and in an abandoned field separate the window decode and the field clear. Progressive fields with one pulse and with none, a window ending on line 63, and a flood of pulses show the mode switch, the line counter's range and count saturation.

// File: rtl/vpd_pkg.sv
`timescale 1ns/1ps
package vpd_pkg;

  typedef enum logic {
    SCAN_SD   = 1'b0,
    SCAN_PROG = 1'b1
  } scan_mode_e;

  // Tail threshold decode: the code order is not monotonic in value.
  function automatic logic [2:0] pulse_threshold(input logic [1:0] code);
    logic [2:0] thr;
    case (code)
      2'b00:   thr = 3'd6;
      2'b01:   thr = 3'd4;
      2'b10:   thr = 3'd5;
      default: thr = 3'd7;
    endcase
    return thr;
  endfunction

  // First tail line: end-2, clipped to the start of a short window.
  function automatic int tail_first_line(input int start_l, input int end_l);
    return (end_l >= start_l + 2) ? end_l - 2 : start_l;
  endfunction

  // Saturating increment for a counter of the given width.
  function automatic int sat_inc(input int value, input int width);
    int top;
    top = (1 << width) - 1;
    return (value >= top) ? top : value + 1;
  endfunction

endpackage

// File: rtl/vpd_line_tracker.sv
`timescale 1ns/1ps
module vpd_line_tracker #(
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start,
  input  logic              hsync,
  input  logic [LINE_W-1:0] end_line,
  output logic [LINE_W-1:0] line_q,
  output logic              eval_pulse
);
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic done_q;

  assign eval_pulse = hsync && !field_start && !done_q && (line_q == end_line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      done_q <= 1'b0;
    end else if (field_start) begin
      line_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (hsync && line_q != LINE_MAX) begin
        line_q <= line_q + 1'b1;
      end
      if (eval_pulse) begin
        done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vpd_window_sel.sv
`timescale 1ns/1ps
module vpd_window_sel #(
  parameter int LINE_W        = 6,
  parameter int BUILTIN_START = 12,
  parameter int BUILTIN_END   = 21
) (
  input  logic              win_override,
  input  logic [LINE_W-1:0] reg_start_line,
  input  logic [LINE_W-1:0] reg_end_line,
  input  logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] win_start,
  output logic [LINE_W-1:0] win_end,
  output logic              in_window,
  output logic              in_tail
);
  localparam logic [LINE_W-1:0] FIX_START = LINE_W'(BUILTIN_START);
  localparam logic [LINE_W-1:0] FIX_END   = LINE_W'(BUILTIN_END);

  logic [LINE_W:0] start_plus2;
  logic [LINE_W:0] tail_lo;

  always_comb begin
    win_start = win_override ? reg_start_line : FIX_START;
    win_end   = win_override ? reg_end_line   : FIX_END;
  end

  always_comb begin
    start_plus2 = {1'b0, win_start} + (LINE_W+1)'(2);
    if ({1'b0, win_end} >= start_plus2) begin
      tail_lo = {1'b0, win_end} - (LINE_W+1)'(2);
    end else begin
      tail_lo = {1'b0, win_start};
    end
    in_window = (line_q >= win_start) && (line_q <= win_end);
    in_tail   = in_window && ({1'b0, line_q} >= tail_lo);
  end
endmodule

// File: rtl/vpd_pulse_accum.sv
`timescale 1ns/1ps
module vpd_pulse_accum #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             pulse_strobe,
  input  logic             in_window,
  input  logic             in_tail,
  output logic [CNT_W-1:0] total_q,
  output logic [CNT_W-1:0] tail_q,
  output logic [CNT_W-1:0] total_next,
  output logic [CNT_W-1:0] tail_next
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic hit_win;
  logic hit_tail;

  assign hit_win  = pulse_strobe && in_window;
  assign hit_tail = pulse_strobe && in_tail;

  always_comb begin
    total_next = (hit_win  && total_q != CNT_MAX) ? total_q + 1'b1 : total_q;
    tail_next  = (hit_tail && tail_q  != CNT_MAX) ? tail_q  + 1'b1 : tail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      tail_q  <= '0;
    end else if (clear) begin
      total_q <= '0;
      tail_q  <= '0;
    end else begin
      total_q <= total_next;
      tail_q  <= tail_next;
    end
  end
endmodule

// File: rtl/vpd_verdict.sv
`timescale 1ns/1ps
module vpd_verdict
  import vpd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_pulse,
  input  logic             prog_mode,
  input  logic [1:0]       limit_sel,
  input  logic [CNT_W-1:0] total_next,
  input  logic [CNT_W-1:0] tail_next,
  output logic             detected,
  output logic [CNT_W-1:0] field_pulse_cnt
);
  logic [CNT_W-1:0] thr_w;
  logic             verdict;

  always_comb begin
    thr_w = CNT_W'(pulse_threshold(limit_sel));
    if (scan_mode_e'(prog_mode) == SCAN_PROG) begin
      verdict = (total_next != '0);
    end else begin
      verdict = (tail_next >= thr_w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      detected        <= 1'b0;
      field_pulse_cnt <= '0;
    end else if (eval_pulse) begin
      detected        <= verdict;
      field_pulse_cnt <= total_next;
    end
  end
endmodule

// File: rtl/vid_pulse_window_det.sv
`timescale 1ns/1ps
module vid_pulse_window_det #(
  parameter int LINE_W        = 6,
  parameter int CNT_W         = 8,
  parameter int BUILTIN_START = 12,
  parameter int BUILTIN_END   = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start,
  input  logic              hsync,
  input  logic              pulse_strobe,
  input  logic              prog_mode,
  input  logic              win_override,
  input  logic [LINE_W-1:0] reg_start_line,
  input  logic [LINE_W-1:0] reg_end_line,
  input  logic [1:0]        limit_sel,
  output logic              detected,
  output logic [CNT_W-1:0]  field_pulse_cnt
);
  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] win_start;
  logic [LINE_W-1:0] win_end;
  logic              in_window;
  logic              in_tail;
  logic              eval_pulse;
  logic [CNT_W-1:0]  total_q;
  logic [CNT_W-1:0]  tail_q;
  logic [CNT_W-1:0]  total_next;
  logic [CNT_W-1:0]  tail_next;

  vpd_window_sel #(
    .LINE_W(LINE_W), .BUILTIN_START(BUILTIN_START), .BUILTIN_END(BUILTIN_END)
  ) u_win (
    .win_override(win_override), .reg_start_line(reg_start_line),
    .reg_end_line(reg_end_line), .line_q(line_q), .win_start(win_start),
    .win_end(win_end), .in_window(in_window), .in_tail(in_tail)
  );

  vpd_line_tracker #(.LINE_W(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .hsync(hsync),
    .end_line(win_end), .line_q(line_q), .eval_pulse(eval_pulse)
  );

  vpd_pulse_accum #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(field_start), .pulse_strobe(pulse_strobe),
    .in_window(in_window), .in_tail(in_tail), .total_q(total_q), .tail_q(tail_q),
    .total_next(total_next), .tail_next(tail_next)
  );

  vpd_verdict #(.CNT_W(CNT_W)) u_vrd (
    .clk(clk), .rst_n(rst_n), .eval_pulse(eval_pulse), .prog_mode(prog_mode),
    .limit_sel(limit_sel), .total_next(total_next), .tail_next(tail_next),
    .detected(detected), .field_pulse_cnt(field_pulse_cnt)
  );
endmodule

// File: rtl/vpd_checker.sv
`timescale 1ns/1ps
module vpd_checker #(
  parameter int LINE_W = 6,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              field_start,
  input logic              hsync,
  input logic              prog_mode,
  input logic [LINE_W-1:0] line_q,
  input logic              in_window,
  input logic              eval_pulse,
  input logic [CNT_W-1:0]  total_q,
  input logic [CNT_W-1:0]  tail_q,
  input logic [CNT_W-1:0]  total_next,
  input logic [CNT_W-1:0]  tail_next,
  input logic              detected,
  input logic [CNT_W-1:0]  field_pulse_cnt
);
  localparam logic [LINE_W-1:0] LMAX = {LINE_W{1'b1}};

  AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && !field_start && line_q != LMAX) |=> line_q == $past(line_q) + 1'b1); // R1
  AST_NO_COUNT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_start && !in_window) |=> total_q == $past(total_q)); // R3
  AST_TAIL_WITHIN_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    tail_q <= total_q); // R4
  AST_SD_SHORT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_pulse && !prog_mode && tail_next < 4) |=> !detected); // R5
  AST_SD_LONG_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_pulse && !prog_mode && tail_next >= 7) |=> detected); // R5
  AST_PROG_ANY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_pulse && prog_mode && total_next != '0) |=> detected); // R6
  AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_pulse |=> ($stable(detected) && $stable(field_pulse_cnt))); // R7
  AST_FIELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (total_q == '0 && tail_q == '0 && line_q == '0)); // R10
endmodule

bind vid_pulse_window_det vpd_checker #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .field_start(field_start), .hsync(hsync),
  .prog_mode(prog_mode), .line_q(line_q), .in_window(in_window),
  .eval_pulse(eval_pulse), .total_q(total_q), .tail_q(tail_q),
  .total_next(total_next), .tail_next(tail_next), .detected(detected),
  .field_pulse_cnt(field_pulse_cnt)
);

// File: tb/vid_pulse_window_det_tb.sv
`timescale 1ns/1ps
module vid_pulse_window_det_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       field_start = 1'b0;
  logic       hsync = 1'b0;
  logic       pulse_strobe = 1'b0;
  logic       prog_mode = 1'b0;
  logic       win_override = 1'b0;
  logic [5:0] reg_start_line = 6'd0;
  logic [5:0] reg_end_line = 6'd0;
  logic [1:0] limit_sel = 2'b10;
  logic       detected;
  logic [7:0] field_pulse_cnt;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;
  int pl [64];

  always #10 clk = ~clk;

  vid_pulse_window_det u_dut (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .hsync(hsync),
    .pulse_strobe(pulse_strobe), .prog_mode(prog_mode), .win_override(win_override),
    .reg_start_line(reg_start_line), .reg_end_line(reg_end_line),
    .limit_sel(limit_sel), .detected(detected), .field_pulse_cnt(field_pulse_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit fs, input bit hs, input bit p);
    @(negedge clk);
    field_start = fs; hsync = hs; pulse_strobe = p;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    field_start = 0; hsync = 0; pulse_strobe = 0;
  endtask

  task automatic clear_pl();
    for (int i = 0; i < 64; i++) pl[i] = 0;
  endtask

  // Field with pl[] pulses on each line, then idle sampling point.
  task automatic run_field(input int nlines);
    step(1, 0, 0);
    for (int l = 0; l < nlines; l++) begin
      for (int k = 0; k < pl[l]; k++) step(0, 0, 1);
      step(0, 1, 0);
    end
    idle();
  endtask

  // Bench model of the expected verdict and count.
  task automatic expect_field(input string req, input int s, input int e);
    int thr_tab [4] = '{6, 4, 5, 7};
    int tot = 0, tl = 0, lo, det;
    lo = (e - 2 >= s) ? e - 2 : s;
    for (int l = 0; l < 64; l++) begin
      if (l >= s && l <= e) tot += pl[l];
      if (l >= lo && l >= s && l <= e) tl += pl[l];
    end
    if (tot > 255) tot = 255;
    if (prog_mode) det = (tot > 0) ? 1 : 0;
    else det = (tl >= thr_tab[limit_sel]) ? 1 : 0;
    chk({req, " detected"}, int'(detected), det);
    chk({req, " count"}, int'(field_pulse_cnt), tot);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    idle();
    chk("R9 reset detected", int'(detected), 0);
    chk("R9 reset count", int'(field_pulse_cnt), 0);
    rst_n = 1;
  endtask

  task automatic t_builtin_window();
    prog_mode = 0; win_override = 0; limit_sel = 2'b10;
    reg_start_line = 6'd2; reg_end_line = 6'd4;
    clear_pl();
    for (int l = 12; l <= 21; l++) pl[l] = 1;
    run_field(30);
    expect_field("R2 R5 builtin sparse", 12, 21);
    for (int l = 12; l <= 21; l++) pl[l] = 2;
    run_field(30);
    expect_field("R2 R5 R8 builtin dense", 12, 21);
  endtask

  task automatic t_outside();
    prog_mode = 0; win_override = 0; limit_sel = 2'b01;
    clear_pl();
    pl[11] = 3; pl[22] = 4; pl[19] = 2; pl[20] = 1; pl[21] = 1;
    run_field(30);
    expect_field("R3 outside lines", 12, 21);
    chk("R3 outside count", int'(field_pulse_cnt), 4);
  endtask

  task automatic t_thresholds();
    int thr_tab [4] = '{6, 4, 5, 7};
    prog_mode = 0; win_override = 1; reg_start_line = 6'd3; reg_end_line = 6'd8;
    for (int c = 0; c < 4; c++) begin
      limit_sel = 2'(c);
      clear_pl();
      pl[4] = 3; pl[7] = thr_tab[c] - 1;
      run_field(12);
      expect_field("R4 R5 below threshold", 3, 8);
      chk("R5 below threshold flag", int'(detected), 0);
      pl[7] = thr_tab[c];
      run_field(12);
      expect_field("R4 R5 at threshold", 3, 8);
      chk("R5 at threshold flag", int'(detected), 1);
    end
    // Short window: tail clipped to the start line.
    limit_sel = 2'b01; reg_start_line = 6'd5; reg_end_line = 6'd6;
    clear_pl();
    pl[5] = 2; pl[6] = 2;
    run_field(10);
    expect_field("R4 short window", 5, 6);
  endtask

  task automatic t_register_window();
    prog_mode = 0; win_override = 1; limit_sel = 2'b01;
    reg_start_line = 6'd2; reg_end_line = 6'd6;
    clear_pl();
    pl[12] = 9; pl[20] = 9;
    run_field(25);
    expect_field("R2 register window ignores builtin lines", 2, 6);
    reg_start_line = 6'd9; reg_end_line = 6'd4;
    clear_pl();
    for (int l = 0; l < 12; l++) pl[l] = 2;
    run_field(12);
    chk("R2 empty window count", int'(field_pulse_cnt), 0);
    chk("R2 empty window flag", int'(detected), 0);
  endtask

  task automatic t_progressive();
    prog_mode = 1; win_override = 0; limit_sel = 2'b11;
    clear_pl();
    pl[12] = 1;
    run_field(25);
    expect_field("R6 progressive single pulse", 12, 21);
    clear_pl();
    run_field(25);
    expect_field("R6 progressive no pulse", 12, 21);
    prog_mode = 0;
  endtask

  task automatic t_hold();
    prog_mode = 0; win_override = 0; limit_sel = 2'b10;
    clear_pl();
    for (int l = 19; l <= 21; l++) pl[l] = 3;
    run_field(25);
    chk("R7 pass before hold", int'(detected), 1);
    step(1, 0, 0);
    for (int l = 0; l < 21; l++) step(0, 1, 0);
    idle();
    chk("R7 flag held before window end", int'(detected), 1);
    chk("R7 count held before window end", int'(field_pulse_cnt), 9);
    step(0, 1, 0);
    idle();
    chk("R7 flag updated after window end", int'(detected), 0);
    for (int l = 0; l < 6; l++) step(0, 1, 0);
    idle();
    chk("R7 no second evaluation", int'(field_pulse_cnt), 0);
  endtask

  task automatic t_abandoned_field();
    prog_mode = 0; win_override = 0; limit_sel = 2'b01;
    step(1, 0, 0);
    for (int l = 0; l < 19; l++) step(0, 1, 0);
    for (int k = 0; k < 6; k++) step(0, 0, 1);
    clear_pl();
    pl[20] = 1;
    run_field(25);
    expect_field("R10 abandoned field cleared", 12, 21);
  endtask

  task automatic t_line_range();
    prog_mode = 1; win_override = 1; reg_start_line = 6'd63; reg_end_line = 6'd63;
    clear_pl();
    pl[63] = 2;
    run_field(64);
    expect_field("R1 line 63 reached", 63, 63);
    clear_pl();
    pl[62] = 2;
    run_field(63);
    chk("R1 no evaluation before line 63 ends", int'(field_pulse_cnt), 2);
  endtask

  task automatic t_saturation();
    prog_mode = 1; win_override = 0;
    clear_pl();
    pl[13] = 300;
    run_field(25);
    expect_field("R8 saturated count", 12, 21);
    prog_mode = 0;
  endtask

  initial begin
    t_reset();
    t_builtin_window();
    t_outside();
    t_thresholds();
    t_register_window();
    t_progressive();
    t_hold();
    t_abandoned_field();
    t_line_range();
    t_saturation();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule